// File: doc/BRIEF.md
# Control-Space System Register File

This block is the set of small system registers that a processor reaches through its control address space. It holds the current MMU context number, a system enable byte, a user DVMA byte, a bus error status byte and a diagnostic byte. Each access presents a full address. The top `SEL_W` address bits pick the target register. The rest of the address is an offset.

Accesses complete in one cycle. A response appears on the next cycle, carrying the register contents held before the access, together with an error flag. Writes with side effects also raise single-cycle strobes toward the rest of the system: a context update, an FPU enable change that carries the new bit, and a system DVMA change. The page map, the segment map and the ID PROM are not stored here. Accesses to them go straight out through a combinational pass-through port, and the returned data is captured into the response. Selects that name cache tags, cache data, cache flush, copy, or no register at all are refused.

Top module: `ctlsp_regfile`

## Requirements
- R1: Synchronous active-low reset clears the context, enable, user DVMA, diagnostic and bus error registers, the response and all strobes to zero.
- R2: Any access gives `rsp_valid` on the following cycle. `rsp_rdata` then holds the selected register contents from before the access, zero-extended. For a pass-through select it holds `pt_rdata` as sampled during the access.
- R3: A write to the enable register (select 5) stores every bit except bit 0, the diagnostic bit, which keeps its previous value.
- R4: A write to the context register (select 4) stores the byte and pulses `ctx_upd`. A write to the enable register that flips bit 7 (not-boot) also pulses `ctx_upd`.
- R5: An enable write that flips bit 1 (FPU enable) pulses `fpu_chg`, with `fpu_chg_val` equal to the new bit.
- R6: An enable write that flips bit 2 (system DVMA enable) pulses `dvma_chg`.
- R7: An enable write whose data sets bit 3 (cache) or bit 4 (copy) raises `rsp_err`. The value is still stored.
- R8: Any read or write of the bus error register (select 7) clears it after the access. A `berr_capture` pulse ORs `berr_code` into the register, and a capture wins over a clear in the same cycle.
- R9: A write to the user DVMA register (select 6) while not-boot is set leaves the register unchanged and raises `rsp_err`. In boot state the write is stored.
- R10: Selects 1, 2 and 3 drive `pt_valid` with `pt_kind` 0, 1 and 2 (ID PROM, page map, segment map). `pt_addr` carries the full address for the ID PROM. For the other two it carries only the low offset bits. Segment-map write data is reduced modulo `NUM_PMEG`.
- R11: Selects 0 and 9 to 15 return zero data and raise `rsp_err` for one response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | Access request this cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | ADDR_W | Access address; top SEL_W bits select the register |
| cyc_wdata | input | DATA_W | Write data; byte registers use the low 8 bits |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | DATA_W | Pre-access contents or pass-through data |
| rsp_err | output | 1 | Illegal or unimplemented access |
| pt_valid | output | 1 | Pass-through request |
| pt_write | output | 1 | Pass-through direction |
| pt_kind | output | 2 | 0 ID PROM, 1 page map, 2 segment map |
| pt_addr | output | ADDR_W | Pass-through address |
| pt_wdata | output | DATA_W | Pass-through write data |
| pt_rdata | input | DATA_W | Pass-through read data |
| berr_capture | input | 1 | Record a bus error code |
| berr_code | input | 8 | Bus error status bits |
| ctx_out | output | 8 | Context number |
| enable_out | output | 8 | System enable byte |
| udvma_out | output | 8 | User DVMA byte |
| diag_out | output | 8 | Diagnostic byte |
| ctx_upd | output | 1 | Context update strobe |
| fpu_chg | output | 1 | FPU enable changed strobe |
| fpu_chg_val | output | 1 | New FPU enable value |
| dvma_chg | output | 1 | System DVMA enable changed strobe |

## Verification
The assertions assume that `cyc_valid`, `cyc_write`, `cyc_addr` and `berr_capture` are never unknown outside reset. They also assume that a response error comes only from the three illegal sources, so the block is never given a second access source. The stimulus drives one access at a time, always on the falling edge, with all controls at defined values from reset onward. It raises `berr_capture` only in cycles apart from bus error accesses, except where the capture-over-clear order is itself being checked.

// File: rtl/ctlsp_pkg.sv
// Package: shared select codes, pass-through kinds and enable bit positions
// for the control-space register file. Assumes a 4-bit register select.
package ctlsp_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [3:0] {
        SEL_NONE   = 4'd0,
        SEL_IDPROM = 4'd1,
        SEL_PGMAP  = 4'd2,
        SEL_SEGMAP = 4'd3,
        SEL_CTX    = 4'd4,
        SEL_ENABLE = 4'd5,
        SEL_UDVMA  = 4'd6,
        SEL_BUSERR = 4'd7,
        SEL_DIAG   = 4'd8,
        SEL_CTAGS  = 4'd9,
        SEL_CDATA  = 4'd10,
        SEL_CFLUSH = 4'd11,
        SEL_COPY   = 4'd12
    } ctl_sel_e;

    typedef enum logic [1:0] {
        PT_IDPROM = 2'd0,
        PT_PGMAP  = 2'd1,
        PT_SEGMAP = 2'd2
    } pt_kind_e;

    // Enable register bit positions (neighbours decode these)
    localparam int EN_DIAG    = 0;
    localparam int EN_FPU     = 1;
    localparam int EN_SDVMA   = 2;
    localparam int EN_CACHE   = 3;
    localparam int EN_COPY    = 4;
    localparam int EN_NOTBOOT = 7;

    typedef struct packed {
        logic hit_pt;
        logic hit_ctx;
        logic hit_en;
        logic hit_udvma;
        logic hit_berr;
        logic hit_diag;
        logic unimpl;
    } ctl_dec_t;
endpackage

// File: rtl/ctlsp_decode.sv
// Address decoder: splits an access address into a register select,
// one-hot-style hit flags and the pass-through address. The ID PROM
// window keeps the whole address; every other target keeps only the offset.
// Assumes ADDR_W > SEL_W.
module ctlsp_decode
    import ctlsp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output ctl_sel_e          sel,
    output ctl_dec_t          dec,
    output pt_kind_e          kind,
    output logic [ADDR_W-1:0] pt_addr
);
    localparam int OFF_W = ADDR_W - SEL_W;

    logic [OFF_W-1:0] offset;

    // Pick the select field and the offset field
    always_comb begin
        sel    = ctl_sel_e'(addr[ADDR_W-1 -: SEL_W]);
        offset = addr[OFF_W-1:0];
    end

    // Classify the select into hit flags and pass-through kind
    always_comb begin
        dec  = '0;
        kind = PT_IDPROM;
        unique case (sel)
            SEL_IDPROM: begin dec.hit_pt = 1'b1; kind = PT_IDPROM; end
            SEL_PGMAP:  begin dec.hit_pt = 1'b1; kind = PT_PGMAP;  end
            SEL_SEGMAP: begin dec.hit_pt = 1'b1; kind = PT_SEGMAP; end
            SEL_CTX:    dec.hit_ctx   = 1'b1;
            SEL_ENABLE: dec.hit_en    = 1'b1;
            SEL_UDVMA:  dec.hit_udvma = 1'b1;
            SEL_BUSERR: dec.hit_berr  = 1'b1;
            SEL_DIAG:   dec.hit_diag  = 1'b1;
            default:    dec.unimpl    = 1'b1;
        endcase
    end

    // Mask the address except for the ID PROM window
    always_comb begin
        if (sel == SEL_IDPROM) pt_addr = addr;
        else                   pt_addr = {{SEL_W{1'b0}}, offset};
    end
endmodule

// File: rtl/ctlsp_enable_reg.sv
// System enable register. The diagnostic bit is write-protected, so it
// holds its reset value. Each write compares old and new
// values and raises registered change strobes. It also reports a boot-state
// flip and an illegal cache/copy setting combinationally for the parent.
module ctlsp_enable_reg
    import ctlsp_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_q,
    output logic             boot_flip,
    output logic             illegal,
    output logic             fpu_chg,
    output logic             fpu_val,
    output logic             dvma_chg
);
    logic [REG_W-1:0] en_next;
    logic [REG_W-1:0] flip;

    // Merge written data with the protected diagnostic bit
    always_comb begin
        en_next          = wdata;
        en_next[EN_DIAG] = en_q[EN_DIAG];
        flip             = wr ? (en_q ^ en_next) : '0;
        boot_flip        = flip[EN_NOTBOOT];
        illegal          = wr & (wdata[EN_CACHE] | wdata[EN_COPY]);
    end

    // Hold the enable byte
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= en_next;
    end

    // Register the change strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpu_chg  <= 1'b0;
            fpu_val  <= 1'b0;
            dvma_chg <= 1'b0;
        end else begin
            fpu_chg  <= flip[EN_FPU];
            fpu_val  <= en_next[EN_FPU];
            dvma_chg <= flip[EN_SDVMA];
        end
    end
endmodule

// File: rtl/ctlsp_sysregs.sv
// Plain system bytes: context, user DVMA, diagnostic and bus error status.
// The bus error byte clears after any access and ORs in captured codes. A
// capture in the same cycle as a clear wins. Write qualification is done by
// the parent.
module ctlsp_sysregs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] wdata,
    input  logic             ctx_wr,
    input  logic             udvma_wr,
    input  logic             diag_wr,
    input  logic             berr_acc,
    input  logic             berr_capture,
    input  logic [REG_W-1:0] berr_code,
    output logic [REG_W-1:0] ctx_q,
    output logic [REG_W-1:0] udvma_q,
    output logic [REG_W-1:0] diag_q,
    output logic [REG_W-1:0] berr_q
);
    logic [REG_W-1:0] berr_next;

    // Next bus error value: clear on access, then OR in a capture
    always_comb begin
        berr_next = (berr_acc ? '0 : berr_q) | (berr_capture ? berr_code : '0);
    end

    // Hold the four bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            udvma_q <= '0;
            diag_q  <= '0;
            berr_q  <= '0;
        end else begin
            if (ctx_wr)   ctx_q   <= wdata;
            if (udvma_wr) udvma_q <= wdata;
            if (diag_wr)  diag_q  <= wdata;
            berr_q <= berr_next;
        end
    end
endmodule

// File: rtl/ctlsp_regfile.sv
// Top of the control-space register file. Decodes each single-cycle access,
// updates the register bytes and forwards map/PROM accesses through the
// combinational pass-through port. Returns a registered response with
// the pre-access contents one cycle later. Assumes at most one access per
// cycle and that pt_rdata is valid in the same cycle as pt_valid.
module ctlsp_regfile
    import ctlsp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_PMEG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              pt_valid,
    output logic              pt_write,
    output logic [1:0]        pt_kind,
    output logic [ADDR_W-1:0] pt_addr,
    output logic [DATA_W-1:0] pt_wdata,
    input  logic [DATA_W-1:0] pt_rdata,
    input  logic              berr_capture,
    input  logic [7:0]        berr_code,
    output logic [7:0]        ctx_out,
    output logic [7:0]        enable_out,
    output logic [7:0]        udvma_out,
    output logic [7:0]        diag_out,
    output logic              ctx_upd,
    output logic              fpu_chg,
    output logic              fpu_chg_val,
    output logic              dvma_chg
);
    localparam int REG_W = 8;

    ctl_sel_e          sel;
    ctl_dec_t          dec;
    pt_kind_e          kind;
    logic [REG_W-1:0]  wbyte;
    logic              wr;
    logic              en_wr, ctx_wr, udvma_wr, udvma_bad, diag_wr, berr_acc;
    logic              boot_flip, en_illegal;
    logic [REG_W-1:0]  en_q, ctx_q, udvma_q, diag_q, berr_q;
    logic [DATA_W-1:0] seg_val;
    logic [DATA_W-1:0] rd_next;
    logic              err_next;

    ctlsp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (cyc_addr),
        .sel     (sel),
        .dec     (dec),
        .kind    (kind),
        .pt_addr (pt_addr)
    );

    // Qualify write enables per register
    always_comb begin
        wbyte     = cyc_wdata[REG_W-1:0];
        wr        = cyc_valid & cyc_write;
        en_wr     = wr & dec.hit_en;
        ctx_wr    = wr & dec.hit_ctx;
        diag_wr   = wr & dec.hit_diag;
        udvma_wr  = wr & dec.hit_udvma & ~en_q[EN_NOTBOOT];
        udvma_bad = wr & dec.hit_udvma &  en_q[EN_NOTBOOT];
        berr_acc  = cyc_valid & dec.hit_berr;
    end

    ctlsp_enable_reg #(.REG_W(REG_W)) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (en_wr),
        .wdata     (wbyte),
        .en_q      (en_q),
        .boot_flip (boot_flip),
        .illegal   (en_illegal),
        .fpu_chg   (fpu_chg),
        .fpu_val   (fpu_chg_val),
        .dvma_chg  (dvma_chg)
    );

    ctlsp_sysregs #(.REG_W(REG_W)) u_sysregs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdata        (wbyte),
        .ctx_wr       (ctx_wr),
        .udvma_wr     (udvma_wr),
        .diag_wr      (diag_wr),
        .berr_acc     (berr_acc),
        .berr_capture (berr_capture),
        .berr_code    (berr_code),
        .ctx_q        (ctx_q),
        .udvma_q      (udvma_q),
        .diag_q       (diag_q),
        .berr_q       (berr_q)
    );

    // Drive the pass-through request; segment entries are reduced modulo NUM_PMEG
    always_comb begin
        seg_val  = DATA_W'(32'(wbyte) % 32'(NUM_PMEG));
        pt_valid = cyc_valid & dec.hit_pt;
        pt_write = cyc_write;
        pt_kind  = kind;
        pt_wdata = (kind == PT_SEGMAP) ? seg_val : cyc_wdata;
    end

    // Select the response data and error for this access
    always_comb begin
        rd_next = '0;
        if (dec.hit_pt)         rd_next = pt_rdata;
        else if (dec.hit_ctx)   rd_next = DATA_W'(ctx_q);
        else if (dec.hit_en)    rd_next = DATA_W'(en_q);
        else if (dec.hit_udvma) rd_next = DATA_W'(udvma_q);
        else if (dec.hit_berr)  rd_next = DATA_W'(berr_q);
        else if (dec.hit_diag)  rd_next = DATA_W'(diag_q);
        err_next = cyc_valid & (dec.unimpl | udvma_bad | en_illegal);
    end

    // Register the response and the context update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            ctx_upd   <= 1'b0;
        end else begin
            rsp_valid <= cyc_valid;
            rsp_rdata <= cyc_valid ? rd_next : '0;
            rsp_err   <= err_next;
            ctx_upd   <= ctx_wr | boot_flip;
        end
    end

    // Present the register bytes
    always_comb begin
        ctx_out    = ctx_q;
        enable_out = en_q;
        udvma_out  = udvma_q;
        diag_out   = diag_q;
    end
endmodule

// File: rtl/ctlsp_regfile_chk.sv
// Checker for ctlsp_regfile, bound to every instance. Assumes control
// inputs are defined outside reset and one access per cycle.
module ctlsp_regfile_chk #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_PMEG = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic              cyc_write,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [7:0]        enable_out,
    input logic [7:0]        udvma_out,
    input logic [7:0]        berr_q,
    input logic              berr_capture,
    input logic              fpu_chg,
    input logic              fpu_chg_val,
    input logic              dvma_chg,
    input logic              pt_valid,
    input logic              pt_write,
    input logic [1:0]        pt_kind,
    input logic [DATA_W-1:0] pt_wdata
);
    logic [3:0] sel;
    logic       past_ok;

    // Extract the select field
    always_comb sel = cyc_addr[ADDR_W-1 -: 4];

    // Mark cycles that have a valid previous cycle since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_diag_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_write && sel == 4'd5) |=> (enable_out[0] == $past(enable_out[0])));

    assert_fpu_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && enable_out[1] != $past(enable_out[1])) |-> (fpu_chg && fpu_chg_val == enable_out[1]));

    assert_dvma_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && enable_out[2] != $past(enable_out[2])) |-> dvma_chg);

    assert_berr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && sel == 4'd7 && !berr_capture) |=> (berr_q == 8'd0));

    assert_udvma_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_write && sel == 4'd6 && enable_out[7]) |=> (rsp_err && $stable(udvma_out)));

    assert_seg_mod_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && pt_write && pt_kind == 2'd2) |-> (pt_wdata < DATA_W'(NUM_PMEG)));

    assert_unimpl_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (sel == 4'd0 || sel >= 4'd9)) |=> (rsp_err && rsp_rdata == '0));
endmodule

bind ctlsp_regfile ctlsp_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PMEG(NUM_PMEG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid    (cyc_valid),
    .cyc_write    (cyc_write),
    .cyc_addr     (cyc_addr),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .enable_out   (enable_out),
    .udvma_out    (udvma_out),
    .berr_q       (berr_q),
    .berr_capture (berr_capture),
    .fpu_chg      (fpu_chg),
    .fpu_chg_val  (fpu_chg_val),
    .dvma_chg     (dvma_chg),
    .pt_valid     (pt_valid),
    .pt_write     (pt_write),
    .pt_kind      (pt_kind),
    .pt_wdata     (pt_wdata)
);

// File: tb/tb_ctlsp_regfile.sv
module tb_ctlsp_regfile;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_valid = 1'b0, cyc_write = 1'b0;
    logic [ADDR_W-1:0] cyc_addr = '0;
    logic [DATA_W-1:0] cyc_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              pt_valid, pt_write;
    logic [1:0]        pt_kind;
    logic [ADDR_W-1:0] pt_addr;
    logic [DATA_W-1:0] pt_wdata;
    logic [DATA_W-1:0] pt_rdata = 32'hCAFE_0042;
    logic              berr_capture = 1'b0;
    logic [7:0]        berr_code = '0;
    logic [7:0]        ctx_out, enable_out, udvma_out, diag_out;
    logic              ctx_upd, fpu_chg, fpu_chg_val, dvma_chg;

    int checks = 0;
    int fails  = 0;
    logic              s_pt_valid;
    logic [1:0]        s_pt_kind;
    logic [ADDR_W-1:0] s_pt_addr;
    logic [DATA_W-1:0] s_pt_wdata;

    always #10 clk = ~clk;

    ctlsp_regfile dut (.*);

    // {write, select, wdata, expected rdata, expected err}
    localparam logic [21:0] VEC [0:14] = '{
        {1'b0, 4'd4,  8'h00, 8'h00, 1'b0},
        {1'b1, 4'd4,  8'h05, 8'h00, 1'b0},
        {1'b0, 4'd4,  8'h00, 8'h05, 1'b0},
        {1'b1, 4'd8,  8'h3C, 8'h00, 1'b0},
        {1'b0, 4'd8,  8'h00, 8'h3C, 1'b0},
        {1'b1, 4'd6,  8'h77, 8'h00, 1'b0},
        {1'b0, 4'd6,  8'h00, 8'h77, 1'b0},
        {1'b1, 4'd5,  8'h87, 8'h00, 1'b0},
        {1'b0, 4'd5,  8'h00, 8'h86, 1'b0},
        {1'b1, 4'd6,  8'h11, 8'h77, 1'b1},
        {1'b0, 4'd6,  8'h00, 8'h77, 1'b0},
        {1'b0, 4'd9,  8'h00, 8'h00, 1'b1},
        {1'b1, 4'd5,  8'h08, 8'h86, 1'b1},
        {1'b0, 4'd5,  8'h00, 8'h08, 1'b0},
        {1'b1, 4'd5,  8'h00, 8'h08, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, snapshot pass-through, return after the response edge
    task automatic op(input logic w, input logic [3:0] s, input logic [27:0] off, input logic [31:0] d);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = w; cyc_addr = {s, off}; cyc_wdata = d;
        #1;
        s_pt_valid = pt_valid; s_pt_kind = pt_kind; s_pt_addr = pt_addr; s_pt_wdata = pt_wdata;
        @(negedge clk);
        cyc_valid = 1'b0; cyc_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset enable", {24'h0, enable_out}, 32'h0);
        check("R1 reset ctx", {24'h0, ctx_out}, 32'h0);
        rst_n = 1'b1;

        // Vector table walk (R2, R3, R9, R7, R11)
        for (int i = 0; i < 15; i++) begin
            op(VEC[i][21], VEC[i][20:17], 28'h0, {24'h0, VEC[i][16:9]});
            check("R2 vector valid", {31'h0, rsp_valid}, 32'h1);
            check("R2 vector rdata", rsp_rdata, {24'h0, VEC[i][8:1]});
            check("R7/R9/R11 vector err", {31'h0, rsp_err}, {31'h0, VEC[i][0]});
        end
        check("R9 udvma kept", {24'h0, udvma_out}, 32'h77);

        // Mid-run reset clears every byte (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 ctx", {24'h0, ctx_out}, 32'h0);
        check("R1 diag", {24'h0, diag_out}, 32'h0);
        check("R1 udvma", {24'h0, udvma_out}, 32'h0);
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;

        // Context write strobe (R4)
        op(1'b1, 4'd4, 28'h0, 32'h09);
        check("R4 ctx stored", {24'h0, ctx_out}, 32'h09);
        check("R4 ctx_upd on ctx write", {31'h0, ctx_upd}, 32'h1);

        // Enable 0x00 -> 0x82: boot flip and FPU on (R4, R5, R6)
        op(1'b1, 4'd5, 28'h0, 32'h82);
        check("R4 boot flip ctx_upd", {31'h0, ctx_upd}, 32'h1);
        check("R5 fpu_chg", {31'h0, fpu_chg}, 32'h1);
        check("R5 fpu_chg_val", {31'h0, fpu_chg_val}, 32'h1);
        check("R6 no dvma_chg", {31'h0, dvma_chg}, 32'h0);

        // 0x82 -> 0x86: only DVMA changes (R6)
        op(1'b1, 4'd5, 28'h0, 32'h86);
        check("R6 dvma_chg", {31'h0, dvma_chg}, 32'h1);
        check("R5 no fpu_chg", {31'h0, fpu_chg}, 32'h0);
        check("R4 no ctx_upd", {31'h0, ctx_upd}, 32'h0);

        // 0x86 -> write 0x01: diag bit protected, back to boot (R3, R5)
        op(1'b1, 4'd5, 28'h0, 32'h01);
        check("R3 diag bit protected", {24'h0, enable_out}, 32'h00);
        check("R5 fpu off value", {31'h0, fpu_chg_val}, 32'h0);
        check("R4 boot flip back", {31'h0, ctx_upd}, 32'h1);

        // Bus error capture, read, clear (R8)
        @(negedge clk); berr_capture = 1'b1; berr_code = 8'h42;
        @(negedge clk); berr_capture = 1'b0; berr_code = 8'h00;
        op(1'b0, 4'd7, 28'h0, 32'h0);
        check("R8 berr read", rsp_rdata, 32'h42);
        op(1'b0, 4'd7, 28'h0, 32'h0);
        check("R8 berr cleared", rsp_rdata, 32'h0);
        // Capture coincides with an access: capture wins (R8)
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b1; cyc_addr = {4'd7, 28'h0};
        berr_capture = 1'b1; berr_code = 8'h11;
        @(negedge clk);
        cyc_valid = 1'b0; cyc_write = 1'b0; berr_capture = 1'b0;
        op(1'b0, 4'd7, 28'h0, 32'h0);
        check("R8 capture beats clear", rsp_rdata, 32'h11);

        // Segment map pass-through (R10)
        op(1'b1, 4'd3, 28'h0001234, 32'd200);
        check("R10 seg pt_valid", {31'h0, s_pt_valid}, 32'h1);
        check("R10 seg kind", {30'h0, s_pt_kind}, 32'h2);
        check("R10 seg addr masked", s_pt_addr, 32'h0000_1234);
        check("R10 seg modulo", s_pt_wdata, 32'd72);

        // ID PROM read keeps full address, returns pass-through data (R10, R2)
        op(1'b0, 4'd1, 28'h0000007, 32'h0);
        check("R10 idprom full addr", s_pt_addr, 32'h1000_0007);
        check("R2 idprom data", rsp_rdata, 32'hCAFE_0042);

        // Unimplemented select 15 (R11)
        op(1'b1, 4'd15, 28'h0, 32'hFF);
        check("R11 err", {31'h0, rsp_err}, 32'h1);
        check("R11 zero data", rsp_rdata, 32'h0);
        op(1'b0, 4'd4, 28'h0, 32'h0);
        check("R11 err one cycle", {31'h0, rsp_err}, 32'h0);

        // User DVMA write in boot state succeeds (R9)
        op(1'b1, 4'd6, 28'h0, 32'h33);
        check("R9 boot write stored", {24'h0, udvma_out}, 32'h33);
        check("R9 boot write no err", {31'h0, rsp_err}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule